// File: doc/BRIEF.md
# Host Interrupt Status Controller

This block gathers single-cycle event pulses from up to `NUM_SRC` internal interrupt sources. Each pulse sets a sticky bit in a pending-status vector. A mask register chooses which pending bits may reach the host. The host drives one interrupt line from the pending bits that are not masked. The host reaches all state through a small register port that does one access per cycle, with address, write enable, write data, read enable and read data.

The same mask and status state can be changed through several windows:

- The mask can be loaded whole.
- Mask bits can be raised or dropped one by one through two write-only windows. A 1 in the written word acts on that bit and a 0 leaves it alone.
- Status can be read without disturbing it.
- Status can be read and emptied in the same access.
- Status can be acknowledged bit by bit through a write-one-to-clear window.

When an event pulse lands in the same cycle as a clear of its own bit, the event wins.

The default source map is:

| Bit | Source |
|-----|--------|
| 0 | receive buffer A ready |
| 1 | transmit data |
| 2 | transmit transfer |
| 3 | receive buffer B ready |
| 4 | receive transfer |
| 5, 6 | mailbox events A and B |
| 7 | wake |
| 8, 9 | trace A and B |
| 10 | command done |
| 14 | start-up done |
| 16, 17 | coexistence sense on and off |

Bits that have no source stay at 0 because nothing pulses them.

Top module: `hint_ctrl`

## Requirements
- R1: After reset the mask reads 1 (only source 0 masked), status reads 0, `host_irq_o` is 0 and `rd_data_o` is 0.
- R2: A 1 on `evt_i[i]` sets status bit i. The bit stays set until it is cleared, and it is seen at the peek window (address 3).
- R3: A write to the mask window (address 0) loads `wr_data_i[NUM_SRC-1:0]`. Reading address 0 returns the mask. A mask bit at 1 blocks that source from the host line.
- R4: A write to the mask-set window (address 1) sets every mask bit that is written as 1 and leaves the others unchanged.
- R5: A write to the mask-clear window (address 2) clears every mask bit that is written as 1 and leaves the others unchanged.
- R6: A read of the peek window (address 3) returns status and leaves it unchanged.
- R7: A read of the take window (address 4) returns status as it was before that cycle's edge and then clears every status bit.
- R8: A write to the acknowledge window (address 5) clears every status bit that is written as 1. A 0 has no effect, and the change is seen at both status windows.
- R9: An event on bit i in the same cycle as an acknowledge or take that clears bit i leaves bit i set.
- R10: `host_irq_o` equals the OR of (status AND NOT mask) as held one clock earlier, so it is one register behind the state.
- R11: Reads of addresses 1, 2, 5, 6 and 7 return 0. Writes to addresses 3, 4, 6 and 7 change neither mask nor status.
- R12: `rd_data_o` carries the read result in the cycle after `rd_en_i` and is 0 in every cycle that follows no read. Bits at and above `NUM_SRC` always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_SRC | Event pulses, one per source |
| addr_i | input | 3 | Register window select |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | DATA_W | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | DATA_W | Read data, registered |
| host_irq_o | output | 1 | Host interrupt line, active high |

## Verification
Results fall due at fixed points relative to the edge that samples a stimulus:

- Mask and status changes are due right after that edge.
- Read data is due right after the edge that samples `rd_en_i`.
- The host line is due one edge later than the status or mask change that causes it.

The bench drives inputs on falling edges and samples every output on the next falling edge. A behavioural model updates on each rising edge, so every comparison lands half a cycle after the register that produced the value. Directed checks of the host line wait the extra cycle explicitly, and they also confirm that the line has not yet moved one cycle early.

// File: rtl/hint_pkg.sv
package hint_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        WIN_MASK = 3'd0,
        WIN_MSET = 3'd1,
        WIN_MCLR = 3'd2,
        WIN_PEEK = 3'd3,
        WIN_TAKE = 3'd4,
        WIN_ACK  = 3'd5,
        WIN_RSV6 = 3'd6,
        WIN_RSV7 = 3'd7
    } hint_win_e;

    typedef struct packed {
        logic mask_load;
        logic mask_set;
        logic mask_clr;
        logic stat_ack;
        logic stat_take;
    } hint_strobe_t;

endpackage

// File: rtl/hint_decode.sv
module hint_decode
    import hint_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    output hint_strobe_t      strb_o,
    output hint_win_e         win_o
);
    hint_win_e win;

    always_comb begin
        win    = hint_win_e'(addr_i);
        strb_o = '0;
        unique case (win)
            WIN_MASK: strb_o.mask_load = wr_en_i;
            WIN_MSET: strb_o.mask_set  = wr_en_i;
            WIN_MCLR: strb_o.mask_clr  = wr_en_i;
            WIN_ACK:  strb_o.stat_ack  = wr_en_i;
            WIN_TAKE: strb_o.stat_take = rd_en_i;
            WIN_PEEK, WIN_RSV6, WIN_RSV7: strb_o = '0;
        endcase
    end

    assign win_o = win;
endmodule

// File: rtl/hint_mask_reg.sv
module hint_mask_reg #(
    parameter int              NUM_SRC  = 22,
    parameter logic [NUM_SRC-1:0] MASK_RST = NUM_SRC'(1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic               set_i,
    input  logic               clr_i,
    input  logic [NUM_SRC-1:0] bits_i,
    output logic [NUM_SRC-1:0] mask_o
);
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] mask_d;

    always_comb begin
        mask_d = mask_q;
        if (load_i) begin
            mask_d = bits_i;
        end else if (set_i) begin
            mask_d = mask_q | bits_i;
        end else if (clr_i) begin
            mask_d = mask_q & ~bits_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= MASK_RST;
        end else begin
            mask_q <= mask_d;
        end
    end

    assign mask_o = mask_q;
endmodule

// File: rtl/hint_status_reg.sv
module hint_status_reg #(
    parameter int NUM_SRC = 22
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    input  logic               take_i,
    input  logic               ack_i,
    input  logic [NUM_SRC-1:0] ack_bits_i,
    output logic [NUM_SRC-1:0] stat_o
);
    logic [NUM_SRC-1:0] stat_q;
    logic [NUM_SRC-1:0] drop;

    always_comb begin
        drop = '0;
        if (take_i) begin
            drop = '1;
        end else if (ack_i) begin
            drop = ack_bits_i;
        end
    end

    // Per-bit update: a pulse on the same bit overrides any clear.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stat_q[i] <= 1'b0;
            end else if (evt_i[i]) begin
                stat_q[i] <= 1'b1;
            end else if (drop[i]) begin
                stat_q[i] <= 1'b0;
            end
        end
    end

    assign stat_o = stat_q;
endmodule

// File: rtl/hint_irq_out.sv
module hint_irq_out #(
    parameter int NUM_SRC = 22
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] stat_i,
    input  logic [NUM_SRC-1:0] mask_i,
    output logic               irq_o
);
    logic irq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |(stat_i & ~mask_i);
        end
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/hint_ctrl.sv
module hint_ctrl
    import hint_pkg::*;
#(
    parameter int NUM_SRC = 22,
    parameter int DATA_W  = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   evt_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic                 wr_en_i,
    input  logic [DATA_W-1:0]    wr_data_i,
    input  logic                 rd_en_i,
    output logic [DATA_W-1:0]    rd_data_o,
    output logic                 host_irq_o
);
    localparam int PAD_W = DATA_W - NUM_SRC;
    localparam logic [NUM_SRC-1:0] MASK_RST = NUM_SRC'(1);

    hint_strobe_t       strb;
    hint_win_e          win;
    logic [NUM_SRC-1:0] wbits;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] stat_q;
    logic [NUM_SRC-1:0] rd_sel;
    logic [DATA_W-1:0]  rd_q;

    assign wbits = wr_data_i[NUM_SRC-1:0];

    hint_decode u_dec (
        .addr_i  (addr_i),
        .wr_en_i (wr_en_i),
        .rd_en_i (rd_en_i),
        .strb_o  (strb),
        .win_o   (win)
    );

    hint_mask_reg #(.NUM_SRC(NUM_SRC), .MASK_RST(MASK_RST)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (strb.mask_load),
        .set_i  (strb.mask_set),
        .clr_i  (strb.mask_clr),
        .bits_i (wbits),
        .mask_o (mask_q)
    );

    hint_status_reg #(.NUM_SRC(NUM_SRC)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_i),
        .take_i     (strb.stat_take),
        .ack_i      (strb.stat_ack),
        .ack_bits_i (wbits),
        .stat_o     (stat_q)
    );

    hint_irq_out #(.NUM_SRC(NUM_SRC)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .stat_i (stat_q),
        .mask_i (mask_q),
        .irq_o  (host_irq_o)
    );

    always_comb begin
        unique case (win)
            WIN_MASK:           rd_sel = mask_q;
            WIN_PEEK, WIN_TAKE: rd_sel = stat_q;
            WIN_MSET, WIN_MCLR, WIN_ACK,
            WIN_RSV6, WIN_RSV7: rd_sel = '0;
        endcase
    end

    generate
        if (PAD_W > 0) begin : g_pad
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    rd_q <= '0;
                end else begin
                    rd_q <= rd_en_i ? {{PAD_W{1'b0}}, rd_sel} : '0;
                end
            end
        end else begin : g_nopad
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    rd_q <= '0;
                end else begin
                    rd_q <= rd_en_i ? DATA_W'(rd_sel) : '0;
                end
            end
        end
    endgenerate

    assign rd_data_o = rd_q;
endmodule

// File: rtl/hint_ctrl_chk.sv
module hint_ctrl_chk
    import hint_pkg::*;
#(
    parameter int NUM_SRC = 22,
    parameter int DATA_W  = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_SRC-1:0]  evt_i,
    input logic [ADDR_W-1:0]   addr_i,
    input logic                wr_en_i,
    input logic [DATA_W-1:0]   wr_data_i,
    input logic                rd_en_i,
    input logic [DATA_W-1:0]   rd_data_o,
    input logic                host_irq_o,
    input logic [NUM_SRC-1:0]  mask_q,
    input logic [NUM_SRC-1:0]  stat_q
);
    // R9
    evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((stat_q & $past(evt_i)) == $past(evt_i)));

    // R7
    take_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i == WIN_TAKE && evt_i == '0) |=> (stat_q == '0));

    // R4
    mset_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == WIN_MSET)
        |=> ((mask_q & $past(wr_data_i[NUM_SRC-1:0])) == $past(wr_data_i[NUM_SRC-1:0])));

    // R5
    mclr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == WIN_MCLR)
        |=> ((mask_q & $past(wr_data_i[NUM_SRC-1:0])) == '0));

    // R6
    peek_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i == WIN_PEEK && !wr_en_i && evt_i == '0) |=> $stable(stat_q));

    // R10
    irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i == '0 && !wr_en_i && !rd_en_i) |=> (host_irq_o == |($past(stat_q) & ~$past(mask_q))));

    // R12
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> (rd_data_o == '0));
endmodule

bind hint_ctrl hint_ctrl_chk #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (evt_i),
    .addr_i     (addr_i),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .rd_en_i    (rd_en_i),
    .rd_data_o  (rd_data_o),
    .host_irq_o (host_irq_o),
    .mask_q     (mask_q),
    .stat_q     (stat_q)
);

// File: tb/tb_hint_ctrl.sv
`timescale 1ns/1ps
module tb_hint_ctrl;
    localparam int NS = 22;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] evt = '0;
    logic [2:0]    addr = '0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] rd_data;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    hint_ctrl #(.NUM_SRC(NS), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .addr_i(addr),
        .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_en_i(rd_en),
        .rd_data_o(rd_data), .host_irq_o(irq)
    );

    // behavioural reference
    bit [NS-1:0] m_mask, m_stat, s_next, wb;
    bit [DW-1:0] m_rd;
    bit          m_irq;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mask = 1; m_stat = 0; m_rd = 0; m_irq = 0;
        end else begin
            m_irq = (m_stat & ~m_mask) != 0;
            m_rd = 0;
            if (rd_en) begin
                if (addr == 0) m_rd = DW'(m_mask);
                else if (addr == 3 || addr == 4) m_rd = DW'(m_stat);
            end
            wb = wr_data[NS-1:0];
            s_next = m_stat;
            if (rd_en && addr == 4) s_next = 0;
            else if (wr_en && addr == 5) s_next = s_next & ~wb;
            s_next = s_next | evt;
            m_stat = s_next;
            if (wr_en) begin
                if (addr == 0) m_mask = wb;
                else if (addr == 1) m_mask = m_mask | wb;
                else if (addr == 2) m_mask = m_mask & ~wb;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_chk++;
            if (rd_data !== m_rd) begin
                n_bad++;
                $display("FAIL R12 model rd_data actual=%h expected=%h", rd_data, m_rd);
            end
            n_chk++;
            if (irq !== m_irq) begin
                n_bad++;
                $display("FAIL R10 model irq actual=%0b expected=%0b", irq, m_irq);
            end
        end
    end

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic [NS-1:0] e, input logic w, input logic r,
                       input logic [2:0] a, input logic [DW-1:0] d, output logic [DW-1:0] v);
        @(negedge clk);
        evt = e; wr_en = w; rd_en = r; addr = a; wr_data = d;
        @(negedge clk);
        v = rd_data;
        evt = '0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [DW-1:0] v);
        cyc('0, 1'b0, 1'b1, a, '0, v);
    endtask

    task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
        logic [DW-1:0] v;
        cyc('0, 1'b1, 1'b0, a, d, v);
    endtask

    task automatic pulse(input logic [NS-1:0] e);
        logic [DW-1:0] v;
        cyc(e, 1'b0, 1'b0, 3'd0, '0, v);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] v;
        logic [31:0]   lf;
        repeat (3) @(negedge clk);
        check("R1 rd_data in reset", rd_data, '0);
        check("R1 irq in reset", DW'(irq), '0);
        rst_n = 1'b1;
        rd(3'd0, v); check("R1 mask reset value", v, 32'h1);
        rd(3'd3, v); check("R1 status reset value", v, 32'h0);

        pulse(22'h1);
        @(negedge clk);
        check("R3 masked source keeps irq low", DW'(irq), '0);
        rd(3'd3, v); check("R2 event latched", v, 32'h1);

        pulse(22'h20);
        check("R10 irq not yet high", DW'(irq), '0);
        @(negedge clk);
        check("R10 irq high one cycle later", DW'(irq), 32'h1);

        rd(3'd3, v); check("R6 first peek", v, 32'h21);
        rd(3'd3, v); check("R6 second peek unchanged", v, 32'h21);

        wr(3'd5, 32'h0);
        rd(3'd3, v); check("R8 zero ack no effect", v, 32'h21);
        wr(3'd5, 32'h20);
        rd(3'd3, v); check("R8 ack clears bit 5", v, 32'h1);
        rd(3'd4, v); check("R8 ack seen at take view", v, 32'h1);
        pulse(22'h1);
        @(negedge clk);
        check("R10 irq low when only masked bit pending", DW'(irq), '0);

        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, v); check("R12 mask load upper bits read zero", v, 32'h003F_FFFF);
        wr(3'd2, 32'h21);
        rd(3'd0, v); check("R5 mask clear", v, 32'h003F_FFDE);
        wr(3'd1, 32'h1);
        rd(3'd0, v); check("R4 mask set", v, 32'h003F_FFDF);
        wr(3'd0, 32'h0);
        rd(3'd0, v); check("R3 mask direct load", v, 32'h0);
        @(negedge clk);
        check("R3 unmasked pending drives irq", DW'(irq), 32'h1);

        pulse(22'h6);
        rd(3'd4, v); check("R7 take returns status", v, 32'h7);
        rd(3'd3, v); check("R7 take emptied status", v, 32'h0);
        @(negedge clk);
        check("R10 irq low after take", DW'(irq), '0);

        cyc(22'h8, 1'b1, 1'b0, 3'd5, 32'h8, v);
        rd(3'd3, v); check("R9 event beats ack", v, 32'h8);
        cyc(22'h10, 1'b0, 1'b1, 3'd4, '0, v);
        check("R9 take returns pre-edge status", v, 32'h8);
        rd(3'd3, v); check("R9 event beats take", v, 32'h10);

        rd(3'd1, v); check("R11 mask-set reads zero", v, '0);
        rd(3'd2, v); check("R11 mask-clear reads zero", v, '0);
        rd(3'd5, v); check("R11 ack reads zero", v, '0);
        rd(3'd6, v); check("R11 addr 6 reads zero", v, '0);
        rd(3'd7, v); check("R11 addr 7 reads zero", v, '0);
        wr(3'd3, 32'hFFFF_FFFF);
        wr(3'd4, 32'hFFFF_FFFF);
        wr(3'd6, 32'hFFFF_FFFF);
        wr(3'd7, 32'hFFFF_FFFF);
        rd(3'd3, v); check("R11 view writes leave status", v, 32'h10);
        rd(3'd0, v); check("R11 view writes leave mask", v, 32'h0);

        lf = 32'hACE1_2345;
        for (int i = 0; i < 600; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            @(negedge clk);
            evt     = (lf[3:0] == 0) ? NS'(lf >> 7) : '0;
            wr_en   = lf[5] & lf[9];
            rd_en   = lf[6];
            addr    = lf[12:10];
            wr_data = {lf[15:0], lf[31:16]};
        end
        @(negedge clk);
        evt = '0; wr_en = 1'b0; rd_en = 1'b0;
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule